// File: doc/BRIEF.md
# Phase Current Averaging and Over-Current Trip

This block sits between the per-phase current digitizers and the PWM generator of a multi-phase buck controller. For each phase it times the moment the current should be sampled: one third of a switching period after that phase's low-side switch turns on. It then collects one digitized sample per active phase and forms the mean over the active phases only, which may number two, three or four. From that mean it derives three results:

- a signed per-phase balance term (sample minus mean), which the PWM generator subtracts from that phase's duty command;
- a scaled droop term, which lowers the regulation target as load rises;
- a single-cycle over-current pulse, raised when the mean exceeds 165% of a programmable full-scale value.

All results are registered once per switching period, in the cycle after the last active phase has delivered its sample. Division by two and by four are shifts. Division by three is a fixed-point reciprocal multiply. Analog sensing and conversion are outside the block.

Top module: `phase_current_share`

## Requirements
- R1: After reset, `avg_out`, every `corr_out` lane, `droop_out`, `oc_pulse` and `sample_req` are all zero.
- R2: A pulse on `ls_on[i]` of an active phase makes `sample_req[i]` high for exactly one cycle. That cycle comes D clock edges after the edge that saw `ls_on[i]`, with D = floor(`period_cyc`/3), or D = 1 when that quotient is zero. Inactive phases never raise `sample_req`.
- R3: `act_cnt` is a 3-bit phase count. Values 0, 1 and 2 select two phases (0 and 1), 3 selects phases 0 to 2, and 4 to 7 select all four. `avg_out` is floor(sum of active samples / active count).
- R4: The outputs update in the cycle after every active phase has delivered at least one valid sample since the last update. A phase that delivers twice before that contributes its latest value.
- R5: Samples on inactive phases are ignored: they neither complete a period nor change the mean, and the `corr_out` lane of an inactive phase is zero.
- R6: The `corr_out` lane of an active phase is that phase's sample minus `avg_out`, in two's complement, SW+1 bits wide. Lane i occupies bits [i*(SW+1) +: SW+1].
- R7: `droop_out` equals floor(`avg_out` * DROOP_NUM / 2^DROOP_SHIFT). With the defaults this is floor(3*avg/4).
- R8: `oc_pulse` is high for the single update cycle in which 20*avg > 33*`full_scale`. The test is strict, uses the mean and not any single phase, and is low in every other cycle.
- R9: Between updates, `avg_out`, `corr_out` and `droop_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| act_cnt | input | 3 | Number of active phases (clamped to 2..4) |
| period_cyc | input | PW | Switching period in clock cycles |
| ls_on | input | NUM_PH | Per-phase low-side turn-on pulse |
| sample_req | output | NUM_PH | Per-phase sample-now pulse |
| smp_valid | input | NUM_PH | Per-phase sample strobe |
| smp_data | input | NUM_PH*SW | Per-phase unsigned samples, phase i at [i*SW +: SW] |
| full_scale | input | SW | Nominal full-load sample value |
| avg_out | output | SW | Mean of active samples |
| corr_out | output | NUM_PH*(SW+1) | Signed per-phase balance terms |
| droop_out | output | DW | Scaled droop term |
| oc_pulse | output | 1 | Over-current pulse |

## Verification
The bench uses sums that are not multiples of three, so that a reciprocal constant that is off by one, or truncates at the wrong place, shows up as a mean one unit low. It places the mean exactly at and one unit past 165% of full scale: a design that tests with `>=`, or that checks a single phase, either trips when it should not or misses the trip. Stray strobes on inactive phases carry large values; a design that does not mask them shifts the mean or completes a period early. Other cases hit the clamped phase counts, a period that is partly delivered and then refreshed, and the timer's zero-quotient floor, where a design without the floor would never request a sample.

// File: rtl/ph_pkg.sv
package ph_pkg;
    localparam int NUM_PH = 4;

    typedef enum logic [1:0] {
        PH_TWO   = 2'd0,
        PH_THREE = 2'd1,
        PH_FOUR  = 2'd2
    } ph_mode_e;

    function automatic ph_mode_e mode_of(input logic [2:0] cnt);
        if (cnt <= 3'd2)      return PH_TWO;
        else if (cnt == 3'd3) return PH_THREE;
        else                  return PH_FOUR;
    endfunction

    function automatic logic [NUM_PH-1:0] mask_of(input ph_mode_e m);
        case (m)
            PH_TWO:   return 4'b0011;
            PH_THREE: return 4'b0111;
            default:  return 4'b1111;
        endcase
    endfunction
endpackage

// File: rtl/phase_div3.sv
module phase_div3 #(
    parameter int W = 12
) (
    input  logic [W-1:0] num,
    output logic [W-1:0] quo
);
    // odd shift makes (2^K+1)/3 an integer; exact floor for num < 2^K
    localparam int K = (W % 2 == 0) ? W + 1 : W + 2;
    localparam longint unsigned RECIP = ((64'd1 << K) + 64'd1) / 64'd3;
    localparam int PW = W + K;

    logic [PW-1:0] prod;

    always_comb begin
        prod = PW'(num) * PW'(RECIP);
        quo  = W'(prod >> K);
    end
endmodule

// File: rtl/phase_third_timer.sv
module phase_third_timer #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          start,
    input  logic [PW-1:0] third,
    output logic          req
);
    typedef struct packed {
        logic [PW-1:0] cnt;
        logic          run;
        logic          req;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d     = tmr_q;
        tmr_d.req = 1'b0;
        if (start && en) begin
            tmr_d.cnt = (third == '0) ? PW'(1) : third;
            tmr_d.run = 1'b1;
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == PW'(1)) begin
                tmr_d.run = 1'b0;
                tmr_d.req = en;
            end else begin
                tmr_d.cnt = tmr_q.cnt - PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign req = tmr_q.req;

    // R2: a running countdown never sits at zero
    p_cnt_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.run |-> (tmr_q.cnt != '0));

    // R2: a request only ends a countdown that was running
    p_req_after_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.req |-> $past(tmr_q.run));
endmodule

// File: rtl/phase_mean.sv
module phase_mean
    import ph_pkg::*;
#(
    parameter int SW = 10
) (
    input  logic [NUM_PH*SW-1:0] smp,
    input  ph_mode_e             mode,
    output logic [SW+1:0]        sum,
    output logic [SW-1:0]        avg
);
    localparam int SUMW = SW + 2;

    logic [NUM_PH-1:0] mask;
    logic [SUMW-1:0]   third;

    always_comb begin
        mask = mask_of(mode);
        sum  = '0;
        for (int i = 0; i < NUM_PH; i++) begin
            if (mask[i]) sum = sum + SUMW'(smp[i*SW +: SW]);
        end
    end

    phase_div3 #(.W(SUMW)) i_div3 (
        .num (sum),
        .quo (third)
    );

    always_comb begin
        case (mode)
            PH_TWO:   avg = SW'(sum >> 1);
            PH_THREE: avg = SW'(third);
            default:  avg = SW'(sum >> 2);
        endcase
    end
endmodule

// File: rtl/phase_current_share.sv
module phase_current_share
    import ph_pkg::*;
#(
    parameter int SW          = 10,
    parameter int PW          = 16,
    parameter int DROOP_NUM   = 3,
    parameter int DROOP_SHIFT = 2,
    localparam int DW         = SW + $clog2(DROOP_NUM + 1),
    localparam int CW         = SW + 1,
    localparam int TW         = SW + 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           act_cnt,
    input  logic [PW-1:0]        period_cyc,
    input  logic [NUM_PH-1:0]    ls_on,
    output logic [NUM_PH-1:0]    sample_req,
    input  logic [NUM_PH-1:0]    smp_valid,
    input  logic [NUM_PH*SW-1:0] smp_data,
    input  logic [SW-1:0]        full_scale,
    output logic [SW-1:0]        avg_out,
    output logic [NUM_PH*CW-1:0] corr_out,
    output logic [DW-1:0]        droop_out,
    output logic                 oc_pulse
);
    typedef struct packed {
        logic [NUM_PH*SW-1:0] smp;
        logic [NUM_PH-1:0]    got;
        logic [SW-1:0]        avg;
        logic [NUM_PH*CW-1:0] corr;
        logic [DW-1:0]        droop;
        logic                 oc;
    } st_t;

    st_t st_d, st_q;

    ph_mode_e          mode;
    logic [NUM_PH-1:0] mask;
    logic [NUM_PH-1:0] take;
    logic              upd;
    logic [SW+1:0]     mean_sum;
    logic [SW-1:0]     mean_avg;
    logic [PW-1:0]     third;

    assign mode = mode_of(act_cnt);
    assign mask = mask_of(mode);
    assign take = smp_valid & mask;
    assign upd  = &(st_q.got | ~mask);

    phase_div3 #(.W(PW)) i_period_div3 (
        .num (period_cyc),
        .quo (third)
    );

    for (genvar g = 0; g < NUM_PH; g++) begin : g_tmr
        phase_third_timer #(.PW(PW)) i_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (mask[g]),
            .start (ls_on[g]),
            .third (third),
            .req   (sample_req[g])
        );
    end

    phase_mean #(.SW(SW)) i_mean (
        .smp  (st_q.smp),
        .mode (mode),
        .sum  (mean_sum),
        .avg  (mean_avg)
    );

    always_comb begin
        st_d    = st_q;
        st_d.oc = 1'b0;
        for (int i = 0; i < NUM_PH; i++) begin
            if (take[i]) st_d.smp[i*SW +: SW] = smp_data[i*SW +: SW];
        end
        st_d.got = upd ? take : (st_q.got | take);
        if (upd) begin
            st_d.avg   = mean_avg;
            st_d.droop = DW'((DW'(mean_avg) * DW'(DROOP_NUM)) >> DROOP_SHIFT);
            st_d.oc    = (TW'(mean_avg) * TW'(20)) > (TW'(full_scale) * TW'(33));
            for (int i = 0; i < NUM_PH; i++) begin
                if (mask[i])
                    st_d.corr[i*CW +: CW] = CW'({1'b0, st_q.smp[i*SW +: SW]})
                                          - CW'({1'b0, mean_avg});
                else
                    st_d.corr[i*CW +: CW] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign avg_out   = st_q.avg;
    assign corr_out  = st_q.corr;
    assign droop_out = st_q.droop;
    assign oc_pulse  = st_q.oc;

    // R3: reciprocal divide gives the exact floor of the active sum
    p_mean_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((TW'(mean_avg) * TW'(mode == PH_TWO ? 2 : (mode == PH_THREE ? 3 : 4))) <= TW'(mean_sum)) &&
        (TW'(mean_sum) < (TW'(mean_avg) + TW'(1)) * TW'(mode == PH_TWO ? 2 : (mode == PH_THREE ? 3 : 4))));

    // R9: the mean holds unless a period completed in the cycle before
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(upd) |-> $stable(st_q.avg));

    // R8: the trip pulse only follows a completed period
    p_oc_on_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.oc |-> $past(upd));
endmodule

// File: tb/test_phase_current_share.sv
module test_phase_current_share;
    localparam int SW = 10;
    localparam int PW = 16;
    localparam int NP = 4;
    localparam int CW = SW + 1;
    localparam int DW = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       act_cnt = 3'd4;
    logic [PW-1:0]    period_cyc = '0;
    logic [NP-1:0]    ls_on = '0;
    logic [NP-1:0]    sample_req;
    logic [NP-1:0]    smp_valid = '0;
    logic [NP*SW-1:0] smp_data = '0;
    logic [SW-1:0]    full_scale = 10'd50;
    logic [SW-1:0]    avg_out;
    logic [NP*CW-1:0] corr_out;
    logic [DW-1:0]    droop_out;
    logic             oc_pulse;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    phase_current_share i_phase_current_share (
        .clk(clk), .rst_n(rst_n), .act_cnt(act_cnt), .period_cyc(period_cyc),
        .ls_on(ls_on), .sample_req(sample_req), .smp_valid(smp_valid),
        .smp_data(smp_data), .full_scale(full_scale), .avg_out(avg_out),
        .corr_out(corr_out), .droop_out(droop_out), .oc_pulse(oc_pulse)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int corr_of(input int i);
        return int'($signed(corr_out[i*CW +: CW]));
    endfunction

    // drive one strobe cycle; the last sample lands on the edge after the call
    task automatic drive(input logic [NP-1:0] v, input int s0, input int s1, input int s2, input int s3);
        @(negedge clk);
        smp_valid = v;
        smp_data  = {SW'(s3), SW'(s2), SW'(s1), SW'(s0)};
        @(posedge clk);
        @(negedge clk);
        smp_valid = '0;
    endtask

    // outputs register on the edge after the last capture
    task automatic settle;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_res(input string tag, input int a, input int c0, input int c1,
                           input int c2, input int c3, input int oc);
        chk(int'(avg_out) == a, {tag, " R3 avg"}, int'(avg_out), a);
        chk(corr_of(0) == c0, {tag, " R6 corr0"}, corr_of(0), c0);
        chk(corr_of(1) == c1, {tag, " R6 corr1"}, corr_of(1), c1);
        chk(corr_of(2) == c2, {tag, " R6 corr2"}, corr_of(2), c2);
        chk(corr_of(3) == c3, {tag, " R6 corr3"}, corr_of(3), c3);
        chk(int'(droop_out) == (a * 3) / 4, {tag, " R7 droop"}, int'(droop_out), (a * 3) / 4);
        chk(int'(oc_pulse) == oc, {tag, " R8 oc"}, int'(oc_pulse), oc);
    endtask

    task automatic t_reset;
        chk(avg_out == '0 && corr_out == '0, "R1 avg/corr zero", int'(avg_out), 0);
        chk(droop_out == '0 && !oc_pulse && sample_req == '0, "R1 droop/oc/req zero",
            int'(droop_out), 0);
    endtask

    task automatic t_timer(input int ch, input int act, input int period, input int exp_first,
                           input int exp_cnt);
        int first = 0;
        int cnt = 0;
        act_cnt = 3'(act);
        period_cyc = PW'(period);
        @(negedge clk);
        ls_on[ch] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ls_on[ch] = 1'b0;
        for (int k = 1; k <= 16; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (sample_req[ch]) begin
                cnt++;
                if (first == 0) first = k;
            end
        end
        chk(first == exp_first, $sformatf("R2 req delay ch%0d period %0d", ch, period), first, exp_first);
        chk(cnt == exp_cnt, $sformatf("R2 req count ch%0d", ch), cnt, exp_cnt);
    endtask

    task automatic t_four_phase;
        act_cnt = 3'd4; full_scale = 10'd50;
        drive(4'b1111, 40, 50, 60, 70);
        settle();
        chk_res("four", 55, -15, -5, 5, 15, 0);
        settle();
        chk(!oc_pulse, "R8 low after update", int'(oc_pulse), 0);
    endtask

    task automatic t_three_masked;
        act_cnt = 3'd3;
        drive(4'b1111, 10, 11, 13, 500);
        settle();
        chk_res("three R5 masked", 11, -1, 0, 2, 0, 0);
    endtask

    task automatic t_trip_edge;
        act_cnt = 3'd2; full_scale = 10'd50;
        drive(4'b1100, 0, 0, 1000, 1000);
        settle();
        chk(int'(avg_out) == 11, "R5 inactive strobes leave mean", int'(avg_out), 11);
        drive(4'b1111, 82, 83, 1000, 1000);
        settle();
        chk_res("two at trip", 82, 0, 1, 0, 0, 0);
        drive(4'b0011, 83, 84, 0, 0);
        settle();
        chk_res("two past trip", 83, 0, 1, 0, 0, 1);
        settle();
        chk(!oc_pulse, "R8 single cycle pulse", int'(oc_pulse), 0);
        full_scale = 10'd600;
        drive(4'b0011, 990, 990, 0, 0);
        settle();
        chk(!oc_pulse, "R8 equal is no trip", int'(oc_pulse), 0);
        drive(4'b0011, 991, 991, 0, 0);
        settle();
        chk(oc_pulse, "R8 one above trips", int'(oc_pulse), 1);
        full_scale = 10'd50;
    endtask

    task automatic t_single_hot;
        act_cnt = 3'd4;
        drive(4'b1111, 200, 0, 0, 0);
        settle();
        chk_res("R8 one hot phase", 50, 150, -50, -50, -50, 0);
    endtask

    task automatic t_partial;
        act_cnt = 3'd3;
        drive(4'b0011, 30, 33, 0, 0);
        repeat (4) settle();
        chk(int'(avg_out) == 50, "R9 hold on partial period", int'(avg_out), 50);
        chk(corr_of(0) == 150, "R9 corr hold", corr_of(0), 150);
        drive(4'b0101, 36, 0, 33, 0);
        settle();
        chk_res("R4 latest sample", 34, 2, -1, -1, 0, 0);
    endtask

    task automatic t_clamp;
        act_cnt = 3'd7;
        drive(4'b1111, 1, 2, 3, 6);
        settle();
        chk_res("R3 count 7 as 4", 3, -2, -1, 0, 3, 0);
        act_cnt = 3'd0;
        drive(4'b0011, 9, 4, 0, 0);
        settle();
        chk_res("R3 count 0 as 2", 6, 3, -2, 0, 0, 0);
    endtask

    task automatic t_max;
        act_cnt = 3'd3;
        drive(4'b0111, 1023, 1023, 1022, 0);
        settle();
        chk_res("R3 max three", 1022, 1, 1, 0, 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_timer(0, 4, 30, 10, 1);
        t_timer(1, 4, 31, 10, 1);
        t_timer(2, 3, 2, 1, 1);
        t_timer(3, 2, 30, 0, 0);
        t_four_phase();
        t_three_masked();
        t_trip_edge();
        t_single_hot();
        t_partial();
        t_clamp();
        t_max();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule